// File: doc/BRIEF.md
# Slew-Limited Voltage Reference Tracker

This block produces the reference value, in millivolts, that a core-voltage regulation loop compares its output against. A 7-bit voltage-identification code arrives together with the millivolt setpoint that a separate lookup has already derived from it. The block filters code changes so that bit skew during a transition is never acted on. A change becomes an accepted target only once the code has been held unchanged for a programmable number of clock cycles. At the default 20 cycles and a 50 MHz clock, that is 400 ns.

In steady state the reference is the latched setpoint. When a new target differs from the present value, the reference is taken from a slew-limited follower. The follower moves toward the target by a fixed step each clock cycle. The step size depends on the kind of transition, which is classified from the direction of the move, two sleep-control inputs and a boot-transition flag. When the follower lands exactly on the target, the block returns to direct tracking. A code accepted mid-ramp retargets the follower without leaving transient mode. While a ramp is running, or while a code change is waiting out its hold time, the block asks the power stage to run all phases.

Top module: `vref_slew_tracker`

## Requirements
- R1: A code change is accepted only after `vid_code` has stayed unchanged for `KEEPOUT_CYC` consecutive clock edges. With a change applied just before edge e0, acceptance happens at edge e0+`KEEPOUT_CYC`. A change that reverts earlier is ignored, and the reference does not move.
- R2: During reset, `vref_mv`, `xfer_active` and `force_multi` are 0. The first code accepted after reset loads its setpoint directly into `vref_mv`, with no ramp and with `xfer_active` staying 0.
- R3: While `xfer_active` is 0, `vref_mv` equals the setpoint latched at the last acceptance and does not change.
- R4: Without `boot_xfer`, a downward move (deep-sleep entry) steps by `BASE_STEP_MV` per cycle.
- R5: Without `boot_xfer`, an upward move with `sleep_ctl` low (fast sleep exit) steps by `FAST_MULT`×`BASE_STEP_MV` per cycle.
- R6: Without `boot_xfer`, an upward move with `sleep_ctl` high steps by `BASE_STEP_MV` per cycle. This covers the slow exit, where `stop_ctl` is also high.
- R7: With `boot_xfer` high at acceptance, the step is `BASE_STEP_MV` in either direction, whatever `sleep_ctl` and `stop_ctl` are.
- R8: The follower never passes the target. The final step is clamped, so a move of D millivolts at step S keeps `xfer_active` high for exactly ceil(D/S) cycles.
- R9: `xfer_active` rises at the acceptance edge when the new setpoint differs from the present reference. It clears on the first cycle in which the reference equals the target, and the reference then holds the target.
- R10: A code accepted while a ramp runs replaces the target and the step without `xfer_active` dropping. The ramp ends on the newest target.
- R11: `force_multi` is 1 whenever `xfer_active` is 1, or whenever the present code differs from the last accepted code after the first acceptance, regardless of `sleep_ctl` and `stop_ctl`. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vid_code | input | CODE_W | Raw voltage-identification code |
| setpoint_mv | input | MV_W | Setpoint in mV derived from `vid_code` |
| sleep_ctl | input | 1 | Deep-sleep request level |
| stop_ctl | input | 1 | Deeper-stop level; selects slow exit together with `sleep_ctl` |
| boot_xfer | input | 1 | Boot-to-target transition in progress |
| vref_mv | output | MV_W | Reference for the regulation loop |
| xfer_active | output | 1 | Slew-limited transient in progress |
| force_multi | output | 1 | Request to run all phases |

## Verification
A wrong hold counter shows as `xfer_active` rising one or more cycles away from edge e0+`KEEPOUT_CYC`, or as a short glitch that moves `vref_mv`. Either is visible within one keep-out window of the code change. A wrong step selection or a missing clamp shows on the first ramp cycle, as a per-cycle change larger than the expected step, and at the end of the ramp, as a wrong cycle count or a final value off target. A lost retarget or a stuck transient flag shows as `xfer_active` dropping early or never clearing. The bench checks for both within a few hundred cycles.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

   typedef enum logic [1:0] {
      XF_BOOT      = 2'd0,
      XF_ENTRY     = 2'd1,
      XF_FAST_EXIT = 2'd2,
      XF_SLOW_EXIT = 2'd3
   } xfer_kind_e;

   // Classify a transition from the boot flag, the move direction and the
   // two sleep-control levels.
   function automatic xfer_kind_e classify_xfer(input logic boot,
                                                input logic going_up,
                                                input logic slp,
                                                input logic stp);
      xfer_kind_e k;
      if (boot)             k = XF_BOOT;
      else if (!going_up)   k = XF_ENTRY;
      else if (!slp)        k = XF_FAST_EXIT;
      else if (stp)         k = XF_SLOW_EXIT;
      else                  k = XF_ENTRY;
      return k;
   endfunction

endpackage

// File: rtl/vrt_code_deglitch.sv
module vrt_code_deglitch #(
   parameter int CODE_W      = 7,
   parameter int KEEPOUT_CYC = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_raw,
   output logic              accept,
   output logic              primed,
   output logic              pending
);

   logic [CODE_W-1:0] acc_q;
   logic              primed_q;
   logic              need;

   initial begin
      assert (CODE_W > 0 && CODE_W <= 16) else $fatal(1, "CODE_W out of range");
      assert (KEEPOUT_CYC >= 0) else $fatal(1, "KEEPOUT_CYC negative");
   end

   assign need    = !primed_q || (code_raw != acc_q);
   assign pending = primed_q && (code_raw != acc_q);
   assign primed  = primed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         primed_q <= 1'b0;
      end else if (accept) begin
         acc_q    <= code_raw;
         primed_q <= 1'b1;
      end
   end

   generate
      if (KEEPOUT_CYC == 0) begin : g_direct
         assign accept = need;
      end else begin : g_hold
         localparam int CNT_W = $clog2(KEEPOUT_CYC + 1);
         localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(KEEPOUT_CYC);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(KEEPOUT_CYC - 1);

         logic [CODE_W-1:0] samp_q;
         logic [CNT_W-1:0]  cnt_q;
         logic              stable;
         logic              past_ok_q;

         assign stable = (code_raw == samp_q);
         assign accept = stable && (cnt_q == CNT_LAST) && need;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               samp_q    <= '0;
               cnt_q     <= '0;
               past_ok_q <= 1'b0;
            end else begin
               past_ok_q <= 1'b1;
               if (!stable) begin
                  samp_q <= code_raw;
                  cnt_q  <= '0;
               end else if (cnt_q != CNT_TOP) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end

         // R1
         keepout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok_q && accept) |-> (code_raw == $past(code_raw)));

         // R1
         cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNT_TOP);
      end
   endgenerate

endmodule

// File: rtl/vrt_rate_select.sv
module vrt_rate_select
   import vrt_pkg::*;
#(
   parameter int MV_W         = 12,
   parameter int BASE_STEP_MV = 5,
   parameter int FAST_MULT    = 3
) (
   input  logic            boot,
   input  logic            going_up,
   input  logic            slp,
   input  logic            stp,
   output logic [MV_W-1:0] step_mv
);

   localparam int FAST_STEP_MV = BASE_STEP_MV * FAST_MULT;

   initial begin
      assert (BASE_STEP_MV > 0) else $fatal(1, "BASE_STEP_MV must be positive");
      assert (FAST_MULT >= 1) else $fatal(1, "FAST_MULT must be at least 1");
      assert (FAST_STEP_MV < (1 << MV_W)) else $fatal(1, "fast step exceeds MV_W");
   end

   xfer_kind_e kind;

   assign kind = classify_xfer(boot, going_up, slp, stp);

   generate
      if (FAST_MULT == 1) begin : g_single_rate
         // One rate for every transition kind; kind still decoded for clarity.
         logic unused_kind;
         assign unused_kind = ^kind;
         assign step_mv = MV_W'(BASE_STEP_MV);
      end else begin : g_dual_rate
         always_comb begin
            unique case (kind)
               XF_FAST_EXIT: step_mv = MV_W'(FAST_STEP_MV);
               XF_BOOT,
               XF_ENTRY,
               XF_SLOW_EXIT: step_mv = MV_W'(BASE_STEP_MV);
               default:      step_mv = MV_W'(BASE_STEP_MV);
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/vrt_slew_follower.sv
module vrt_slew_follower #(
   parameter int MV_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_direct,
   input  logic            retarget,
   input  logic [MV_W-1:0] new_tgt,
   input  logic [MV_W-1:0] new_step,
   output logic [MV_W-1:0] flw_q,
   output logic [MV_W-1:0] tgt_q,
   output logic            active_q
);

   logic [MV_W-1:0] step_q;
   logic [MV_W-1:0] gap;
   logic [MV_W-1:0] flw_nxt;
   logic            up;
   logic            past_ok_q;

   assign up  = (flw_q < tgt_q);
   assign gap = up ? (tgt_q - flw_q) : (flw_q - tgt_q);

   always_comb begin
      if (gap > step_q) flw_nxt = up ? (flw_q + step_q) : (flw_q - step_q);
      else              flw_nxt = tgt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flw_q     <= '0;
         tgt_q     <= '0;
         step_q    <= '0;
         active_q  <= 1'b0;
         past_ok_q <= 1'b0;
      end else begin
         past_ok_q <= 1'b1;
         if (load_direct) begin
            flw_q    <= new_tgt;
            tgt_q    <= new_tgt;
            step_q   <= new_step;
            active_q <= 1'b0;
         end else if (retarget) begin
            tgt_q    <= new_tgt;
            step_q   <= new_step;
            active_q <= (new_tgt != flw_q);
         end else if (active_q) begin
            flw_q    <= flw_nxt;
            active_q <= (flw_nxt != tgt_q);
         end
      end
   end

   // R4
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok_q && $past(active_q)) |->
         (((flw_q >= $past(flw_q)) ? (flw_q - $past(flw_q))
                                   : ($past(flw_q) - flw_q)) <= $past(step_q)));

   // R8
   no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok_q && $past(active_q) && $stable(tgt_q) && ($past(flw_q) <= tgt_q))
         |-> (flw_q <= tgt_q));

   // R9
   settle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok_q && $fell(active_q) && !$past(retarget) && !$past(load_direct))
         |-> (flw_q == tgt_q));

endmodule

// File: rtl/vref_slew_tracker.sv
module vref_slew_tracker #(
   parameter int CODE_W       = 7,
   parameter int MV_W         = 12,
   parameter int KEEPOUT_CYC  = 20,
   parameter int BASE_STEP_MV = 5,
   parameter int FAST_MULT    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] vid_code,
   input  logic [MV_W-1:0]   setpoint_mv,
   input  logic              sleep_ctl,
   input  logic              stop_ctl,
   input  logic              boot_xfer,
   output logic [MV_W-1:0]   vref_mv,
   output logic              xfer_active,
   output logic              force_multi
);

   initial begin
      assert (MV_W >= 4 && MV_W <= 24) else $fatal(1, "MV_W out of range");
   end

   logic            accept;
   logic            primed;
   logic            pending;
   logic            going_up;
   logic [MV_W-1:0] step_sel;
   logic [MV_W-1:0] flw;
   logic [MV_W-1:0] tgt;
   logic            active;
   logic            past_ok_q;

   vrt_code_deglitch #(
      .CODE_W      (CODE_W),
      .KEEPOUT_CYC (KEEPOUT_CYC)
   ) u_deglitch (
      .clk      (clk),
      .rst_n    (rst_n),
      .code_raw (vid_code),
      .accept   (accept),
      .primed   (primed),
      .pending  (pending)
   );

   assign going_up = (setpoint_mv > flw);

   vrt_rate_select #(
      .MV_W         (MV_W),
      .BASE_STEP_MV (BASE_STEP_MV),
      .FAST_MULT    (FAST_MULT)
   ) u_rate (
      .boot     (boot_xfer),
      .going_up (going_up),
      .slp      (sleep_ctl),
      .stp      (stop_ctl),
      .step_mv  (step_sel)
   );

   vrt_slew_follower #(
      .MV_W (MV_W)
   ) u_follow (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_direct (accept && !primed),
      .retarget    (accept && primed),
      .new_tgt     (setpoint_mv),
      .new_step    (step_sel),
      .flw_q       (flw),
      .tgt_q       (tgt),
      .active_q    (active)
   );

   assign vref_mv     = active ? flw : tgt;
   assign xfer_active = active;
   assign force_multi = active || pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok_q <= 1'b0;
      else        past_ok_q <= 1'b1;
   end

   // R3
   steady_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok_q && !active && !$past(active) && $past(primed))
         |-> $stable(vref_mv));

endmodule

// File: tb/test_vref_slew_tracker.sv
module test_vref_slew_tracker;

   localparam int CODE_W = 7;
   localparam int MV_W   = 12;
   localparam int K      = 20;
   localparam int BASE   = 5;
   localparam int MULT   = 3;
   localparam int FAST   = BASE * MULT;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CODE_W-1:0] vid_code = '0;
   logic [MV_W-1:0]   setpoint_mv = '0;
   logic              sleep_ctl = 1'b0;
   logic              stop_ctl = 1'b0;
   logic              boot_xfer = 1'b0;
   logic [MV_W-1:0]   vref_mv;
   logic              xfer_active;
   logic              force_multi;

   always #10 clk = ~clk;

   vref_slew_tracker #(
      .CODE_W (CODE_W), .MV_W (MV_W), .KEEPOUT_CYC (K),
      .BASE_STEP_MV (BASE), .FAST_MULT (MULT)
   ) i_vref_slew_tracker (
      .clk (clk), .rst_n (rst_n), .vid_code (vid_code), .setpoint_mv (setpoint_mv),
      .sleep_ctl (sleep_ctl), .stop_ctl (stop_ctl), .boot_xfer (boot_xfer),
      .vref_mv (vref_mv), .xfer_active (xfer_active), .force_multi (force_multi)
   );

   int errors = 0;
   int checks = 0;

   function automatic int sp(input int c);
      return 300 + 12 * c;
   endfunction

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   typedef struct {
      int tgt;
      int steps;
      int rate;
   } item_t;

   item_t sb[$];

   task automatic push_ramp(input int from_mv, input int to_mv, input int rate);
      item_t it;
      int d;
      d = (to_mv > from_mv) ? to_mv - from_mv : from_mv - to_mv;
      it.tgt = to_mv;
      it.steps = ceil_div(d, rate);
      it.rate = rate;
      sb.push_back(it);
   endtask

   task automatic set_code(input int c);
      @(posedge clk);
      #1;
      vid_code    = CODE_W'(c);
      setpoint_mv = MV_W'(sp(c));
   endtask

   task automatic wait_idle();
      int n;
      n = 0;
      repeat (K + 4) @(negedge clk);
      while (xfer_active && n < 3000) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk);
   endtask

   // Monitor: pops one expected ramp at each rising transient and compares.
   bit    in_ramp = 1'b0;
   int    ramp_cnt = 0;
   int    prev_ref = 0;
   int    start_ref = 0;
   item_t cur;

   always @(negedge clk) begin
      if (rst_n) begin
         if (xfer_active) begin
            if (!in_ramp) begin
               in_ramp   = 1'b1;
               ramp_cnt  = 0;
               start_ref = prev_ref;
               if (sb.size() == 0) begin
                  chk(1'b0, "R9 unexpected transient", 1, 0);
                  cur.tgt = int'(vref_mv); cur.steps = -1; cur.rate = FAST;
               end else begin
                  cur = sb.pop_front();
               end
            end
            ramp_cnt++;
            // R11: all phases forced during any ramp
            chk(force_multi == 1'b1, "R11 force_multi in ramp", int'(force_multi), 1);
            // R4 R5 R6 R7: per-cycle step bounded by the selected rate
            chk(((int'(vref_mv) > prev_ref) ? int'(vref_mv) - prev_ref
                                            : prev_ref - int'(vref_mv)) <= cur.rate,
                "R4/R5/R6/R7 step size", int'(vref_mv) - prev_ref, cur.rate);
            if (cur.steps >= 0) begin
               // R8: never beyond the target
               chk((cur.tgt >= start_ref) ? (int'(vref_mv) <= cur.tgt)
                                          : (int'(vref_mv) >= cur.tgt),
                   "R8 overshoot", int'(vref_mv), cur.tgt);
            end
         end else if (in_ramp) begin
            in_ramp = 1'b0;
            // R9: lands on target
            chk(int'(vref_mv) == cur.tgt, "R9 final ref", int'(vref_mv), cur.tgt);
            if (cur.steps >= 0)
               // R8: exact cycle count from clamped stepping
               chk(ramp_cnt == cur.steps, "R8 ramp cycles", ramp_cnt, cur.steps);
         end
         prev_ref = int'(vref_mv);
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      bit ok;
      vid_code    = CODE_W'(10);
      setpoint_mv = MV_W'(sp(10));
      repeat (3) @(negedge clk);
      // R2: reset state
      chk(vref_mv == '0, "R2 reset vref", int'(vref_mv), 0);
      chk(xfer_active == 1'b0, "R2 reset xfer_active", int'(xfer_active), 0);
      chk(force_multi == 1'b0, "R2 reset force_multi", int'(force_multi), 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R2: first accepted code loads directly
      ok = 1'b1;
      repeat (K + 5) begin
         @(negedge clk);
         if (xfer_active) ok = 1'b0;
      end
      chk(ok, "R2 no ramp on first load", 0, 0);
      chk(int'(vref_mv) == sp(10), "R2 direct load", int'(vref_mv), sp(10));
      chk(force_multi == 1'b0, "R11 idle force_multi", int'(force_multi), 0);

      // R1: glitch shorter than keep-out is ignored; R11 pending forces phases
      set_code(11);
      repeat (3) @(negedge clk);
      chk(force_multi == 1'b1, "R11 pending force_multi", int'(force_multi), 1);
      repeat (K - 8) @(posedge clk);
      set_code(10);
      ok = 1'b1;
      repeat (K + 10) begin
         @(negedge clk);
         if (xfer_active || int'(vref_mv) != sp(10)) ok = 1'b0;
      end
      chk(ok, "R1 glitch ignored", int'(vref_mv), sp(10));
      chk(force_multi == 1'b0, "R11 after glitch", int'(force_multi), 0);

      // R1: exact acceptance edge; R5 fast exit upward
      sleep_ctl = 1'b0;
      push_ramp(sp(10), sp(11), FAST);
      set_code(11);
      repeat (K) @(posedge clk);
      @(negedge clk);
      chk(xfer_active == 1'b0, "R1 not before keep-out", int'(xfer_active), 0);
      chk(int'(vref_mv) == sp(10), "R1 ref held in keep-out", int'(vref_mv), sp(10));
      @(posedge clk);
      @(negedge clk);
      chk(xfer_active == 1'b1, "R1 accepted at keep-out", int'(xfer_active), 1);
      wait_idle();
      chk(int'(vref_mv) == sp(11), "R3 steady ref", int'(vref_mv), sp(11));

      // R4: deep-sleep entry, downward at base rate
      sleep_ctl = 1'b1;
      push_ramp(sp(11), sp(8), BASE);
      set_code(8);
      wait_idle();
      chk(int'(vref_mv) == sp(8), "R4 entry settle", int'(vref_mv), sp(8));

      // R6: slow exit upward at base rate
      stop_ctl = 1'b1;
      push_ramp(sp(8), sp(12), BASE);
      set_code(12);
      wait_idle();

      // R5: fast exit upward at triple rate
      sleep_ctl = 1'b0;
      stop_ctl  = 1'b0;
      push_ramp(sp(12), sp(20), FAST);
      set_code(20);
      wait_idle();

      // R7: boot transition at base rate both ways, sleep inputs ignored
      boot_xfer = 1'b1;
      push_ramp(sp(20), sp(2), BASE);
      set_code(2);
      wait_idle();
      push_ramp(sp(2), sp(40), BASE);
      set_code(40);
      wait_idle();
      chk(int'(vref_mv) == sp(40), "R7 boot settle", int'(vref_mv), sp(40));

      // R10: retarget mid-ramp without leaving transient mode
      begin
         item_t it;
         it.tgt = sp(30); it.steps = -1; it.rate = BASE;
         sb.push_back(it);
      end
      set_code(60);
      repeat (K + 10) @(negedge clk);
      chk(xfer_active == 1'b1, "R10 ramp running", int'(xfer_active), 1);
      set_code(30);
      ok = 1'b1;
      repeat (K + 4) begin
         @(negedge clk);
         if (!xfer_active) ok = 1'b0;
      end
      chk(ok, "R10 xfer_active held across retarget", int'(xfer_active), 1);
      wait_idle();
      chk(int'(vref_mv) == sp(30), "R10 final target", int'(vref_mv), sp(30));

      // R3: steady reference holds while inputs other than code wiggle
      boot_xfer = 1'b0;
      sleep_ctl = 1'b1;
      stop_ctl  = 1'b1;
      ok = 1'b1;
      repeat (20) begin
         @(negedge clk);
         if (int'(vref_mv) != sp(30) || xfer_active || force_multi) ok = 1'b0;
      end
      chk(ok, "R3 steady hold", int'(vref_mv), sp(30));
      chk(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule